// File: doc/BRIEF.md
# Preemptive Priority ADC Conversion Sequencer

This block sequences an external multi-channel analog-to-digital converter. While the scan enable is high, it runs a repeating scan over an inclusive channel window. It starts one conversion at a time through a start/channel handshake and waits for the converter's done pulse. Each normal result goes into a per-channel result memory, and a normal-completion interrupt pulses for each one.

A top-priority request can come from a software set pulse or from a rising edge on one of several hardware trigger lines, chosen by a 2-bit select field. The request cuts into the scan. The conversion in flight is aborted and its data is thrown away. One conversion then runs on the priority channel, and its result goes into a dedicated priority register with its own interrupt. After that the scan continues by converting the suspended channel again.

A request made while the sequencer is idle runs the priority conversion alone and then returns to idle. Requests that arrive while a priority conversion is active are dropped.

Top module: `adc_prio_seq`

## Requirements
- R1: With `scan_en` high and the sequencer idle, conversions run on channels `scan_first`, `scan_first+1`, … up to `scan_last`, then wrap to `scan_first`. Each completion pulses `norm_irq` for one cycle, with `norm_ch` giving the channel. When `scan_en` is low at a normal completion, the sequencer goes idle and starts nothing further.
- R2: A one-cycle `sw_prio_set` pulse seen at a clock edge, while no priority conversion is active, makes `conv_start` high in the next cycle with `conv_ch` equal to `prio_ch`.
- R3: `trig_sel` encoding: 0 = hardware triggers off; 1, 2 and 3 select `hw_trig[0]`, `hw_trig[1]` and `hw_trig[2]`. Only a rising edge of the selected line makes a request. Lines that are not selected, and a line held high, make no further requests.
- R4: A request during a normal conversion gives, in the same cycle, a one-cycle `conv_abort` pulse together with `conv_start` for the priority channel.
- R5: The aborted normal conversion produces no `norm_irq` and no write to the result memory.
- R6: A priority completion loads `prio_result` with the converter data and pulses `prio_irq` for one cycle. The normal result memory is not changed.
- R7: After a preempting priority conversion completes, the next `conv_start` converts the channel that was suspended. The scan order then continues from that channel.
- R8: Requests arriving while `prio_busy` is high are dropped and are not queued.
- R9: `sw_prio_bit` is set when a software request is accepted. It clears on the same edge at which `prio_irq` rises.
- R10: A priority request accepted while idle returns the sequencer to idle after its completion, with no further conversion started.
- R11: Reading the result memory returns, one cycle after `rd_addr` is applied, the latest normal result stored for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Normal scan enable (level) |
| scan_first | input | CH_W | First channel of the scan window |
| scan_last | input | CH_W | Last channel of the scan window |
| sw_prio_set | input | 1 | Software priority request pulse |
| trig_sel | input | 2 | Hardware trigger source select |
| hw_trig | input | NHW | Hardware trigger lines |
| prio_ch | input | CH_W | Channel for priority conversions |
| conv_start | output | 1 | Converter start pulse |
| conv_abort | output | 1 | Cancels the conversion in flight |
| conv_ch | output | CH_W | Channel for the started conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | DATA_W | Converter result, valid with done |
| norm_irq | output | 1 | Normal completion pulse |
| norm_ch | output | CH_W | Channel of the last normal completion |
| prio_irq | output | 1 | Priority completion pulse |
| prio_result | output | DATA_W | Priority result register |
| prio_busy | output | 1 | Priority conversion in progress |
| sw_prio_bit | output | 1 | Software request bit |
| rd_addr | input | CH_W | Result memory read channel |
| rd_data | output | DATA_W | Result memory read data |

## Verification
The assertions assume that the converter never raises `conv_done` in the same cycle as `conv_start`. They also assume that a start or abort discards any conversion already running, and that `scan_first` is not above `scan_last`. The bench's converter model answers a fixed number of cycles after each start and lets a new start override the pending one. Every scan window it programs is ascending. Requests are timed to land mid-conversion, never on the same edge as a done pulse, so the preemption path has one clear expected outcome.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_NORM = 2'd1,
    SQ_PRIO = 2'd2
  } sq_state_e;

  localparam int TSEL_W = 2;
endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig
  import adcseq_pkg::*;
#(
  parameter int NHW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_set,
  input  logic [TSEL_W-1:0] trig_sel,
  input  logic [NHW-1:0]    hw_trig,
  input  logic              busy,
  input  logic              prio_done,
  output logic              req,
  output logic              sw_bit
);
  logic [NHW-1:0] hw_q;
  logic [NHW-1:0] rise;
  logic           hw_hit;

  genvar g;
  generate
    for (g = 0; g < NHW; g++) begin : g_edge
      always_ff @(posedge clk) begin
        if (rst) hw_q[g] <= 1'b0;
        else     hw_q[g] <= hw_trig[g];
      end
      assign rise[g] = hw_trig[g] & ~hw_q[g];
    end
  endgenerate

  always_comb begin
    hw_hit = 1'b0;
    for (int i = 0; i < NHW; i++) begin
      if (trig_sel == TSEL_W'(i + 1)) hw_hit = rise[i];
    end
  end

  assign req = (sw_set | hw_hit) & ~busy;

  always_ff @(posedge clk) begin
    if (rst)                   sw_bit <= 1'b0;
    else if (prio_done)        sw_bit <= 1'b0;
    else if (sw_set && !busy)  sw_bit <= 1'b1;
  end
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_en,
  input  logic [CH_W-1:0]   scan_first,
  input  logic [CH_W-1:0]   scan_last,
  input  logic              prio_req,
  input  logic [CH_W-1:0]   prio_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_start,
  output logic              conv_abort,
  output logic [CH_W-1:0]   conv_ch,
  output logic              norm_irq,
  output logic [CH_W-1:0]   norm_ch,
  output logic [DATA_W-1:0] norm_data,
  output logic              prio_irq,
  output logic [DATA_W-1:0] prio_result,
  output logic              prio_busy,
  output logic              prio_done
);
  sq_state_e       st;
  logic [CH_W-1:0] cur_q;
  logic [CH_W-1:0] nxt;
  logic            resume_q;

  assign nxt       = (cur_q == scan_last) ? scan_first : cur_q + 1'b1;
  assign prio_busy = (st == SQ_PRIO);
  assign prio_done = (st == SQ_PRIO) && conv_done;

  always_ff @(posedge clk) begin
    conv_start <= 1'b0;
    conv_abort <= 1'b0;
    norm_irq   <= 1'b0;
    prio_irq   <= 1'b0;
    if (rst) begin
      st          <= SQ_IDLE;
      cur_q       <= '0;
      resume_q    <= 1'b0;
      conv_ch     <= '0;
      norm_ch     <= '0;
      norm_data   <= '0;
      prio_result <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (prio_req) begin
            conv_start <= 1'b1;
            conv_ch    <= prio_ch;
            resume_q   <= 1'b0;
            st         <= SQ_PRIO;
          end else if (scan_en) begin
            cur_q      <= scan_first;
            conv_start <= 1'b1;
            conv_ch    <= scan_first;
            st         <= SQ_NORM;
          end
        end
        SQ_NORM: begin
          if (prio_req) begin
            // cut in: cur_q is left as is so the same channel reruns later
            conv_abort <= 1'b1;
            conv_start <= 1'b1;
            conv_ch    <= prio_ch;
            resume_q   <= 1'b1;
            st         <= SQ_PRIO;
          end else if (conv_done) begin
            norm_irq  <= 1'b1;
            norm_ch   <= cur_q;
            norm_data <= conv_data;
            cur_q     <= nxt;
            if (scan_en) begin
              conv_start <= 1'b1;
              conv_ch    <= nxt;
            end else begin
              st <= SQ_IDLE;
            end
          end
        end
        SQ_PRIO: begin
          if (conv_done) begin
            prio_irq    <= 1'b1;
            prio_result <= conv_data;
            if (resume_q) begin
              conv_start <= 1'b1;
              conv_ch    <= cur_q;
              st         <= SQ_NORM;
            end else begin
              st <= SQ_IDLE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  p_irq_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(norm_irq && prio_irq));

  p_preempt_aborts_r4: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_NORM && prio_req) |=> conv_abort);

  p_resume_same_ch_r7: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_PRIO && conv_done && resume_q) |=> (conv_start && conv_ch == $past(cur_q)));
endmodule

// File: rtl/adcseq_ram.sv
module adcseq_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/adc_prio_seq.sv
module adc_prio_seq
  import adcseq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int DATA_W = 12,
  parameter int NHW    = 3,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_en,
  input  logic [CH_W-1:0]   scan_first,
  input  logic [CH_W-1:0]   scan_last,
  input  logic              sw_prio_set,
  input  logic [TSEL_W-1:0] trig_sel,
  input  logic [NHW-1:0]    hw_trig,
  input  logic [CH_W-1:0]   prio_ch,
  output logic              conv_start,
  output logic              conv_abort,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              norm_irq,
  output logic [CH_W-1:0]   norm_ch,
  output logic              prio_irq,
  output logic [DATA_W-1:0] prio_result,
  output logic              prio_busy,
  output logic              sw_prio_bit,
  input  logic [CH_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic              req;
  logic              prio_done;
  logic [DATA_W-1:0] norm_data;

  adcseq_trig #(.NHW(NHW)) u_trig (
    .clk(clk), .rst(rst), .sw_set(sw_prio_set), .trig_sel(trig_sel),
    .hw_trig(hw_trig), .busy(prio_busy), .prio_done(prio_done),
    .req(req), .sw_bit(sw_prio_bit)
  );

  adcseq_fsm #(.CH_W(CH_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_first(scan_first),
    .scan_last(scan_last), .prio_req(req), .prio_ch(prio_ch),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_ch(conv_ch), .norm_irq(norm_irq),
    .norm_ch(norm_ch), .norm_data(norm_data), .prio_irq(prio_irq),
    .prio_result(prio_result), .prio_busy(prio_busy), .prio_done(prio_done)
  );

  adcseq_ram #(.DEPTH(NCH), .DW(DATA_W)) u_ram (
    .clk(clk), .we(norm_irq), .wa(norm_ch), .wd(norm_data),
    .ra(rd_addr), .rd(rd_data)
  );

  p_abort_pairs_start_r4: assert property (@(posedge clk) disable iff (rst)
    conv_abort |-> (conv_start && conv_ch == $past(prio_ch)));

  p_busy_drops_req_r8: assert property (@(posedge clk) disable iff (rst)
    (prio_busy && !conv_done) |=> !conv_start);

  p_swbit_clears_r9: assert property (@(posedge clk) disable iff (rst)
    prio_irq |-> !sw_prio_bit);
endmodule

// File: tb/tb_adc_prio_seq.sv
module tb_adc_prio_seq;
  localparam int NCH = 16, CW = 4, DW = 12, NHW = 3, LAT = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, scan_en, sw_prio_set, conv_done;
  logic [CW-1:0] scan_first, scan_last, prio_ch, rd_addr;
  logic [1:0] trig_sel;
  logic [NHW-1:0] hw_trig;
  logic [DW-1:0] conv_data;
  logic conv_start, conv_abort, norm_irq, prio_irq, prio_busy, sw_prio_bit;
  logic [CW-1:0] conv_ch, norm_ch;
  logic [DW-1:0] prio_result, rd_data;

  adc_prio_seq #(.NCH(NCH), .DATA_W(DW), .NHW(NHW)) dut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_first(scan_first),
    .scan_last(scan_last), .sw_prio_set(sw_prio_set), .trig_sel(trig_sel),
    .hw_trig(hw_trig), .prio_ch(prio_ch), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .norm_irq(norm_irq), .norm_ch(norm_ch),
    .prio_irq(prio_irq), .prio_result(prio_result), .prio_busy(prio_busy),
    .sw_prio_bit(sw_prio_bit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // behavioural converter: a start (with or without abort) replaces any pending job
  logic [CW-1:0] m_ch;
  int m_cnt;
  logic m_busy;
  logic [7:0] serial;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (rst) begin
      m_busy <= 1'b0; m_cnt <= 0; m_ch <= '0; serial <= 8'd1; conv_data <= '0;
    end else if (conv_start) begin
      m_busy <= 1'b1; m_cnt <= LAT; m_ch <= conv_ch;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        m_busy <= 1'b0; conv_done <= 1'b1;
        conv_data <= {m_ch, serial}; serial <= serial + 8'd1;
      end else m_cnt <= m_cnt - 1;
    end
  end

  // scoreboard
  int exp_norm[$];
  int exp_prio[$];
  logic [DW-1:0] mon_data [NCH];
  int last_norm_ch = 0, susp_ch = 0, prio_start_ch = 0, e = 0;
  int abort_cnt = 0, start_cnt = 0;
  bit pend_resume = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (conv_start) begin
        start_cnt++;
        if (conv_abort) begin
          chk(prio_busy, "R4 abort comes with priority start", prio_busy, 1);
          pend_resume = 1; susp_ch = last_norm_ch; abort_cnt++;
          prio_start_ch = conv_ch;
        end else if (prio_busy) begin
          prio_start_ch = conv_ch;
        end else begin
          if (pend_resume) begin
            chk(conv_ch == susp_ch, "R7 resume channel", conv_ch, susp_ch);
            pend_resume = 0;
          end
          last_norm_ch = conv_ch;
        end
      end
      if (norm_irq) begin
        if (pend_resume) chk(0, "R5 normal result from aborted conversion", norm_ch, -1);
        if (exp_norm.size() == 0) chk(0, "R1 unexpected normal result", norm_ch, -1);
        else begin
          e = exp_norm.pop_front();
          chk(norm_ch == e, "R1 scan order", norm_ch, e);
          mon_data[norm_ch] = conv_data;
        end
      end
      if (prio_irq) begin
        if (exp_prio.size() == 0) chk(0, "R8 unexpected priority result", prio_start_ch, -1);
        else begin
          e = exp_prio.pop_front();
          chk(prio_start_ch == e, "R6 priority channel", prio_start_ch, e);
          chk(prio_result == conv_data, "R6 priority result", prio_result, conv_data);
        end
      end
    end
  end

  task automatic scan_begin(input int f, input int l, input int n);
    int c = f;
    for (int i = 0; i < n; i++) begin
      exp_norm.push_back(c);
      c = (c == l) ? f : c + 1;
    end
    scan_first = CW'(f); scan_last = CW'(l); scan_en = 1'b1;
  endtask

  task automatic scan_finish();
    int s;
    while (exp_norm.size() > 1) tick();
    scan_en = 1'b0;
    while (exp_norm.size() > 0) tick();
    s = start_cnt;
    repeat (20) tick();
    chk(start_cnt == s, "R1 scan stops after enable low", start_cnt - s, 0);
  endtask

  task automatic sw_pulse(input int ch);
    prio_ch = CW'(ch); sw_prio_set = 1'b1;
    tick();
    sw_prio_set = 1'b0;
  endtask

  task automatic hw_pulse(input int idx);
    hw_trig[idx] = 1'b1;
    tick();
    hw_trig[idx] = 1'b0;
  endtask

  task automatic wait_prio_irq();
    while (!prio_irq) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int s, a;
    rst = 1; scan_en = 0; sw_prio_set = 0; trig_sel = 0; hw_trig = '0;
    scan_first = '0; scan_last = '0; prio_ch = '0; rd_addr = '0;
    repeat (5) tick();
    rst = 0;
    tick();
    chk(!conv_start, "R1 reset no start", conv_start, 0);
    chk(!prio_busy, "R8 reset not busy", prio_busy, 0);
    chk(!sw_prio_bit, "R9 reset bit clear", sw_prio_bit, 0);
    chk(!norm_irq && !prio_irq, "R6 reset no irq", norm_irq | prio_irq, 0);

    // plain scan with wrap
    scan_begin(2, 4, 7);
    scan_finish();

    // software preemption mid-conversion on channel 3
    scan_begin(0, 8, 12);
    do tick(); while (!(conv_start && !prio_busy && conv_ch == 3));
    tick(); tick();
    a = abort_cnt;
    exp_prio.push_back(11);
    sw_pulse(11);
    chk(abort_cnt == a + 1, "R4 abort issued", abort_cnt - a, 1);
    chk(conv_ch == 11, "R2 priority channel driven", conv_ch, 11);
    chk(sw_prio_bit, "R9 bit set on accept", sw_prio_bit, 1);
    trig_sel = 2'd1;
    s = start_cnt;
    hw_pulse(0);
    sw_pulse(7);
    chk(prio_busy, "R8 still busy", prio_busy, 1);
    wait_prio_irq();
    chk(start_cnt == s + 1, "R8 no start from dropped requests", start_cnt - s, 1);
    chk(!sw_prio_bit, "R9 bit cleared at completion", sw_prio_bit, 0);
    trig_sel = 2'd0;
    scan_finish();

    // hardware trigger selection while idle
    s = start_cnt;
    hw_pulse(0); hw_pulse(1); hw_pulse(2);
    repeat (20) tick();
    chk(start_cnt == s, "R3 triggers off", start_cnt - s, 0);
    trig_sel = 2'd2;
    hw_pulse(0);
    repeat (20) tick();
    chk(start_cnt == s, "R3 unselected line ignored", start_cnt - s, 0);
    prio_ch = 4'd5;
    exp_prio.push_back(5);
    hw_trig[1] = 1'b1;
    repeat (40) tick();
    hw_trig[1] = 1'b0;
    chk(start_cnt == s + 1, "R3 one request per rising edge", start_cnt - s, 1);
    chk(exp_prio.size() == 0, "R3 selected line served", exp_prio.size(), 0);
    chk(!prio_busy, "R10 idle after hardware request", prio_busy, 0);
    trig_sel = 2'd0;

    // software request from idle
    exp_prio.push_back(14);
    s = start_cnt;
    sw_pulse(14);
    chk(conv_start && conv_ch == 14, "R2 start on priority channel", conv_ch, 14);
    wait_prio_irq();
    repeat (20) tick();
    chk(start_cnt == s + 1, "R10 no scan after idle request", start_cnt - s, 1);
    chk(!prio_busy, "R10 back to idle", prio_busy, 0);

    // result memory readback; channel 5 must hold the scan value, not the priority one
    for (int ch = 0; ch <= 8; ch++) begin
      rd_addr = CW'(ch);
      tick();
      chk(rd_data == mon_data[ch], (ch == 5) ? "R6 normal memory untouched" : "R11 readback",
          rd_data, mon_data[ch]);
    end

    // hardware preemption on select 3
    scan_begin(5, 6, 6);
    do tick(); while (!(conv_start && !prio_busy && conv_ch == 6));
    tick();
    a = abort_cnt;
    exp_prio.push_back(9);
    prio_ch = 4'd9; trig_sel = 2'd3;
    hw_pulse(2);
    chk(abort_cnt == a + 1, "R4 hardware preemption aborts", abort_cnt - a, 1);
    trig_sel = 2'd0;
    scan_finish();
    chk(exp_prio.size() == 0, "R6 all priority results seen", exp_prio.size(), 0);
    chk(!pend_resume, "R7 resume happened", pend_resume, 0);

    finish_up();
  end
endmodule